// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the command side of a small serial non-volatile memory. It behaves as an SPI slave in clock modes 0 and 3. Each command starts with an 8-bit opcode, usually followed by a 16-bit address and then data, all sent most significant bit first. The block oversamples the serial pins with its system clock, so the serial clock may stop at any point and resume later without losing its place. The storage is a 1024-byte register file behind a 16-entry page buffer. A write is held in the buffer and copied into the array during a busy interval that starts when chip-select rises.

Three mechanisms guard the array. A write-enable latch must be set before each non-volatile write. A write-protect pin refuses all non-volatile writes while it is low. A block-lock field selects one protected region: the first page, the last page, the lower half, or any one quarter. The block-lock field and a two-bit watchdog period field sit in a status byte, and software writes that byte through its own command, which also passes through the busy interval.

There is also a trimming sequence. It runs while an external high-voltage flag is raised. A single-byte write of 00h to address 0001h gives a one-cycle threshold-set pulse. The same write to address 0003h gives a threshold-reset pulse. In both cases the 00h is also stored in the array.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset, the status byte reads 00h, `so_oe` is low, and neither threshold pulse is active.
- R2: No command is decoded until chip-select has gone high and then low after reset. Serial clocks that arrive while chip-select was already low at reset release do nothing.
- R3: Input bits are taken on rising SCK and output bits change on falling SCK, MSB first. A transfer gives identical results in mode 0 (SCK idles low) and mode 3 (SCK idles high).
- R4: Opcode 06h sets the write-enable latch and opcode 04h clears it. A write or status write sent while the latch is clear changes nothing and starts no busy interval.
- R5: Opcode 02h, a 16-bit address and data bytes form a page write. The data address advances and wraps within its 16-byte page, a later byte replaces an earlier one at the same offset, and nothing reaches the array before chip-select rises.
- R6: An accepted write sets status bit 0 for BUSY_CYCLES clocks. During that time every opcode except 05h is ignored, including 06h. The write-enable latch clears when the interval ends.
- R7: While `wp_n` is low, page writes and status writes are refused.
- R8: Status bits [4:2] choose the protected region: 0 none, 1 first page, 2 last page, 3 lower half, 4 to 7 quarter 0 to 3. A page write whose page lies in that region is refused.
- R9: Opcode 03h with a 16-bit address returns bytes from the array. Only the low 10 address bits are used, the address increments after each byte, and it wraps from 3FFh to 000h.
- R10: With `hv_flag` high, an accepted write of exactly one byte 00h at address 0001h pulses `trip_set` for one clock, and at 0003h pulses `trip_reset` for one clock. The byte is also stored. Any other data, address or length, or a low `hv_flag`, gives no pulse.
- R11: `so_oe` is low whenever chip-select is high.
- R12: If chip-select rises when the bit count is not a whole number of bytes, a pending write or status write is dropped.
- R13: The status byte is {0, watchdog[1:0], lock[2:0], latch, busy}, read with opcode 05h. Opcode 01h followed by one byte loads bits [6:2] of that byte into the watchdog and lock fields at the end of the busy interval. The watchdog field also drives `wd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin; low refuses non-volatile writes |
| hv_flag | input | 1 | High-voltage indication that enables the trimming sequence |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Drive enable for `so`; low means the pad is released |
| trip_set | output | 1 | One-clock pulse requesting a threshold raise |
| trip_reset | output | 1 | One-clock pulse requesting a threshold return to native level |
| wd_sel | output | 2 | Watchdog period field from the status byte |

## Verification
Writes are driven with several address and length patterns. An 18-byte burst that starts two bytes before a page end shows whether the buffer wraps within the page and whether later bytes replace earlier ones. A read that crosses 3FFh shows whether the address wraps at the end of the whole array instead of at a page boundary. The same data is written and read in both clock modes, so an edge-polarity fault appears as a mismatch. Refused writes under each guard (clear latch, low protect pin, each lock code, a chip-select rise mid-byte, a busy array) are each followed by a read of a value stored earlier. The trimming sequence is tried with the right and wrong data, the right and wrong address, and with the flag low, so that each condition of the pulse is shown to matter on its own.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WREN  = 8'h06;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRSR,
        CMD_WRITE,
        CMD_READ,
        CMD_RDSR
    } cmd_e;

    typedef enum logic {
        JOB_ARRAY,
        JOB_STATUS
    } job_e;

    // Non-volatile part of the status byte, bits [6:2]
    typedef struct packed {
        logic [1:0] wd_sel;
        logic [2:0] lock;
    } nv_status_t;

    // True when a page index falls inside the region picked by the lock code
    function automatic logic page_locked(input logic [2:0] code,
                                         input logic [15:0] page,
                                         input int page_w);
        logic [15:0] last;
        last = 16'((32'd1 << page_w) - 32'd1);
        case (code)
            3'd1:                   return page == 16'd0;
            3'd2:                   return page == last;
            3'd3:                   return (page >> (page_w - 1)) == 16'd0;
            3'd4, 3'd5, 3'd6, 3'd7: return (page >> (page_w - 2)) == {14'd0, code[1:0]};
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_frontend.sv
module spi_ee_frontend (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       load_en,
    input  logic [7:0] load_byte,
    output logic       sel,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       byte_done,
    output logic       at_boundary,
    output logic [7:0] rx_byte,
    output logic       so
);
    logic [1:0] cs_sync, sck_sync, mosi_sync;
    logic       cs_d, sck_d;
    logic       sck_rise, sck_fall;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr, tx_sr;

    // Two-flop synchronisers; chip-select starts as "low" so that a line
    // already low at reset release never looks like a falling edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sync   <= '0;
            sck_sync  <= '0;
            mosi_sync <= '0;
            cs_d      <= 1'b0;
            sck_d     <= 1'b0;
        end else begin
            cs_sync   <= {cs_sync[0], cs_n};
            sck_sync  <= {sck_sync[0], sck};
            mosi_sync <= {mosi_sync[0], mosi};
            cs_d      <= cs_sync[1];
            sck_d     <= sck_sync[1];
        end
    end

    assign sel      = !cs_sync[1];
    assign cs_fall  = cs_d && !cs_sync[1];
    assign cs_rise  = !cs_d && cs_sync[1];
    assign sck_rise = sel && sck_sync[1] && !sck_d;
    assign sck_fall = sel && !sck_sync[1] && sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            so        <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (cs_fall) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sr   <= {rx_sr[6:0], mosi_sync[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) byte_done <= 1'b1;
            end
            if (load_en) begin
                tx_sr <= load_byte;
            end else if (sck_fall) begin
                so    <= tx_sr[7];
                tx_sr <= {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign rx_byte     = rx_sr;
    assign at_boundary = (bit_cnt == 3'd0);

endmodule

// File: rtl/spi_ee_commit.sv
module spi_ee_commit
    import spi_ee_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int PAGE        = 16,
    parameter int BUSY_CYCLES = 200,
    localparam int AW = $clog2(DEPTH),
    localparam int OW = $clog2(PAGE),
    localparam int PW = AW - OW,
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  job_e          job_in,
    input  logic [PW-1:0] page_in,
    input  logic          buf_clear,
    input  logic          buf_we,
    input  logic [OW-1:0] buf_idx,
    input  logic [7:0]    buf_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          done,
    output job_e          job_q
);
    logic [7:0]      mem  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pvalid;
    logic [CW-1:0]   cnt;
    logic [PW-1:0]   page_q;
    logic            wr_hit;

    always_ff @(posedge clk) begin
        if (rst)            pvalid <= '0;
        else if (buf_clear) pvalid <= '0;
        else if (buf_we)    pvalid[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    // Busy interval; the first PAGE counts copy buffered bytes one per clock
    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            job_q  <= JOB_ARRAY;
            page_q <= '0;
        end else if (!busy && start) begin
            busy   <= 1'b1;
            cnt    <= '0;
            job_q  <= job_in;
            page_q <= page_in;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            cnt <= cnt + CW'(1);
        end
    end

    assign done   = busy && (cnt == CW'(BUSY_CYCLES - 1));
    assign wr_hit = busy && (job_q == JOB_ARRAY) && (cnt < CW'(PAGE))
                    && pvalid[cnt[OW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_hit) mem[{page_q, cnt[OW-1:0]}] <= pbuf[cnt[OW-1:0]];
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_ee_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int PAGE        = 16,
    parameter int BUSY_CYCLES = 200,
    localparam int AW = $clog2(DEPTH),
    localparam int OW = $clog2(PAGE),
    localparam int PW = AW - OW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       wp_n,
    input  logic       hv_flag,
    output logic       so,
    output logic       so_oe,
    output logic       trip_set,
    output logic       trip_reset,
    output logic [1:0] wd_sel
);
    logic          sel, cs_fall, cs_rise, byte_done, at_boundary;
    logic [7:0]    rx_byte;
    logic          load_en;
    logic [7:0]    load_byte;
    logic          busy, done;
    job_e          job_q;
    logic          start;
    job_e          start_job;
    logic          buf_clear, buf_we;
    logic [OW-1:0] buf_idx;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    logic          active;
    cmd_e          cmd_q;
    logic [1:0]    byte_cnt;
    logic [7:0]    addr_hi;
    logic [AW-1:0] addr_q;
    logic [15:0]   start_addr;
    logic [1:0]    data_cnt;
    logic [7:0]    first_data;
    logic          wel;
    nv_status_t    nv_q, pend_nv;
    logic          pend_ok;
    logic [7:0]    status_byte;
    logic          write_ok, single_zero;

    spi_ee_frontend u_front (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (si),
        .load_en    (load_en),
        .load_byte  (load_byte),
        .sel        (sel),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .byte_done  (byte_done),
        .at_boundary(at_boundary),
        .rx_byte    (rx_byte),
        .so         (so)
    );

    spi_ee_commit #(
        .DEPTH      (DEPTH),
        .PAGE       (PAGE),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_commit (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .job_in   (start_job),
        .page_in  (start_addr[AW-1:OW]),
        .buf_clear(buf_clear),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_data (rx_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .busy     (busy),
        .done     (done),
        .job_q    (job_q)
    );

    assign status_byte = {1'b0, nv_q, wel, busy};
    assign so_oe       = sel && active;
    assign wd_sel      = nv_q.wd_sel;

    // Per-byte datapath: what to shift out next and what to buffer
    always_comb begin
        load_en   = 1'b0;
        load_byte = status_byte;
        rd_addr   = addr_q;
        buf_clear = 1'b0;
        buf_we    = 1'b0;
        buf_idx   = addr_q[OW-1:0];
        if (active && byte_done) begin
            if (byte_cnt == 2'd0) begin
                if (rx_byte == OPC_RDSR) load_en = 1'b1;
                else if (rx_byte == OPC_WRITE && !busy) buf_clear = 1'b1;
            end else if (cmd_q == CMD_RDSR) begin
                load_en = 1'b1;
            end else if (cmd_q == CMD_READ && byte_cnt == 2'd2) begin
                rd_addr   = AW'({addr_hi, rx_byte});
                load_en   = 1'b1;
                load_byte = rd_data;
            end else if (cmd_q == CMD_READ && byte_cnt == 2'd3) begin
                load_en   = 1'b1;
                load_byte = rd_data;
            end else if (cmd_q == CMD_WRITE && byte_cnt == 2'd3) begin
                buf_we = 1'b1;
            end
        end
    end

    // Decision taken when chip-select rises
    assign write_ok    = wel && wp_n && !busy && at_boundary;
    assign single_zero = (data_cnt == 2'd1) && (first_data == 8'h00);

    always_comb begin
        start     = 1'b0;
        start_job = JOB_ARRAY;
        if (active && cs_rise && write_ok) begin
            if (cmd_q == CMD_WRITE && data_cnt != 2'd0 &&
                !page_locked(nv_q.lock, 16'(start_addr[AW-1:OW]), PW)) begin
                start = 1'b1;
            end else if (cmd_q == CMD_WRSR && pend_ok) begin
                start     = 1'b1;
                start_job = JOB_STATUS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            cmd_q      <= CMD_NONE;
            byte_cnt   <= '0;
            addr_hi    <= '0;
            addr_q     <= '0;
            start_addr <= '0;
            data_cnt   <= '0;
            first_data <= '0;
            wel        <= 1'b0;
            nv_q       <= '0;
            pend_nv    <= '0;
            pend_ok    <= 1'b0;
            trip_set   <= 1'b0;
            trip_reset <= 1'b0;
        end else begin
            trip_set   <= start && start_job == JOB_ARRAY && hv_flag && single_zero
                          && start_addr == 16'h0001;
            trip_reset <= start && start_job == JOB_ARRAY && hv_flag && single_zero
                          && start_addr == 16'h0003;
            if (cs_fall) begin
                active   <= 1'b1;
                cmd_q    <= CMD_NONE;
                byte_cnt <= '0;
                data_cnt <= '0;
                pend_ok  <= 1'b0;
            end else if (cs_rise) begin
                active <= 1'b0;
            end else if (active && byte_done) begin
                if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
                if (byte_cnt == 2'd0) begin
                    cmd_q <= CMD_NONE;
                    case (rx_byte)
                        OPC_RDSR:  cmd_q <= CMD_RDSR;
                        OPC_READ:  if (!busy) cmd_q <= CMD_READ;
                        OPC_WRITE: if (!busy) cmd_q <= CMD_WRITE;
                        OPC_WRSR:  if (!busy) cmd_q <= CMD_WRSR;
                        OPC_WREN:  if (!busy) wel <= 1'b1;
                        OPC_WRDI:  if (!busy) wel <= 1'b0;
                        default:   cmd_q <= CMD_NONE;
                    endcase
                end else if (byte_cnt == 2'd1) begin
                    addr_hi <= rx_byte;
                    if (cmd_q == CMD_WRSR && !pend_ok) begin
                        pend_nv <= nv_status_t'(rx_byte[6:2]);
                        pend_ok <= 1'b1;
                    end
                end else if (byte_cnt == 2'd2) begin
                    start_addr <= {addr_hi, rx_byte};
                    if (cmd_q == CMD_READ) addr_q <= AW'({addr_hi, rx_byte}) + AW'(1);
                    else                   addr_q <= AW'({addr_hi, rx_byte});
                end else begin
                    if (cmd_q == CMD_READ) addr_q <= addr_q + AW'(1);
                    if (cmd_q == CMD_WRITE) begin
                        addr_q[OW-1:0] <= addr_q[OW-1:0] + OW'(1);
                        if (data_cnt == 2'd0) first_data <= rx_byte;
                        if (data_cnt != 2'd3) data_cnt <= data_cnt + 2'd1;
                    end
                end
            end
            if (done) begin
                wel <= 1'b0;
                if (job_q == JOB_STATUS) nv_q <= pend_nv;
            end
        end
    end

    // R11: output drive released once chip-select has been high a few clocks
    assert_hiz_deselected_R11: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    // R4 and R7: a busy interval only begins with the latch set and wp_n high
    assert_nv_write_gated_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wel) && $past(wp_n)));

    assert_latch_clears_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    assert_busy_freezes_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wel));

    assert_trip_needs_hv_R10: assert property (@(posedge clk) disable iff (rst)
        (trip_set || trip_reset) |-> ($past(hv_flag) && $rose(busy)));

endmodule

// File: tb/spi_eeprom_ctrl_test.sv
module spi_eeprom_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int BUSY       = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic hv_flag = 1'b0;
    logic so, so_oe, trip_set, trip_reset;
    logic [1:0] wd_sel;

    int n_checks = 0;
    int n_fail   = 0;
    int set_cnt  = 0;
    int rst_cnt  = 0;
    logic mode3 = 1'b0;
    logic [7:0] wbuf [0:31];
    logic [7:0] rbuf [0:31];

    spi_eeprom_ctrl #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
        .hv_flag(hv_flag), .so(so), .so_oe(so_oe), .trip_set(trip_set),
        .trip_reset(trip_reset), .wd_sel(wd_sel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst && trip_set)   set_cnt <= set_cnt + 1;
        if (!rst && trip_reset) rst_cnt <= rst_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cs_begin();
        sck = mode3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        sck  = mode3;
        wait_clk(2 * HALF);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            si = tx[i];
            wait_clk(HALF);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(HALF);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] dummy;
        xfer_bits(tx, 8, dummy);
    endtask

    task automatic simple_cmd(input logic [7:0] opc);
        cs_begin();
        send(opc);
        cs_end();
    endtask

    task automatic read_status(output logic [7:0] st);
        cs_begin();
        send(8'h05);
        xfer_bits(8'h00, 8, st);
        cs_end();
    endtask

    task automatic write_status(input logic [7:0] val);
        cs_begin();
        send(8'h01);
        send(val);
        cs_end();
    endtask

    task automatic write_mem(input logic [15:0] addr, input int n);
        cs_begin();
        send(8'h02);
        send(addr[15:8]);
        send(addr[7:0]);
        for (int k = 0; k < n; k++) send(wbuf[k]);
        cs_end();
    endtask

    task automatic read_mem(input logic [15:0] addr, input int n);
        cs_begin();
        send(8'h03);
        send(addr[15:8]);
        send(addr[7:0]);
        for (int k = 0; k < n; k++) xfer_bits(8'h00, 8, rbuf[k]);
        cs_end();
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        st = 8'h01;
        for (int k = 0; k < 30 && st[0]; k++) read_status(st);
    endtask

    task automatic put_byte(input logic [15:0] addr, input logic [7:0] val);
        simple_cmd(8'h06);
        wbuf[0] = val;
        write_mem(addr, 1);
        wait_idle();
    endtask

    task automatic expect_byte(input string req, input logic [15:0] addr, input logic [7:0] val);
        read_mem(addr, 1);
        check(req, {24'd0, rbuf[0]}, {24'd0, val});
    endtask

    task automatic t_power_up();
        logic [7:0] st;
        // cs_n held low through reset: no falling edge yet
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        send(8'h05);
        check("R2 so_oe without cs fall", {31'd0, so_oe}, 32'd0);
        send(8'h06);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        check("R11 so_oe deselected", {31'd0, so_oe}, 32'd0);
        check("R1 trip outputs", {30'd0, trip_set, trip_reset}, 32'd0);
        read_status(st);
        check("R1 R2 status after reset", {24'd0, st}, 32'h00);
    endtask

    task automatic t_latch();
        logic [7:0] st;
        put_byte(16'h0040, 8'h11);
        wbuf[0] = 8'h5A;
        write_mem(16'h0040, 1);
        read_status(st);
        check("R4 no busy without latch", {24'd0, st}, 32'h00);
        expect_byte("R4 write without latch ignored", 16'h0040, 8'h11);
        simple_cmd(8'h06);
        read_status(st);
        check("R4 latch set", {24'd0, st}, 32'h02);
        simple_cmd(8'h04);
        read_status(st);
        check("R4 latch cleared", {24'd0, st}, 32'h00);
    endtask

    task automatic t_page_and_busy();
        logic [7:0] st;
        int src;
        simple_cmd(8'h06);
        for (int k = 0; k < 18; k++) wbuf[k] = 8'h30 + 8'(k);
        write_mem(16'h00AE, 18);
        read_status(st);
        check("R6 busy and latch during write", {24'd0, st}, 32'h03);
        simple_cmd(8'h06);
        wbuf[0] = 8'h99;
        write_mem(16'h00A5, 1);
        wait_idle();
        read_status(st);
        check("R6 latch cleared after busy", {24'd0, st}, 32'h00);
        read_mem(16'h00A0, 16);
        for (int o = 0; o < 16; o++) begin
            src = (o + 2) % 16;
            if (o >= 14) src = o + 2;
            check("R5 page wrap contents", {24'd0, rbuf[o]}, 32'h30 + src);
        end
    endtask

    task automatic t_modes();
        mode3 = 1'b1;
        simple_cmd(8'h06);
        wbuf[0] = 8'h3C;
        wbuf[1] = 8'hC3;
        write_mem(16'h0123, 2);
        wait_idle();
        read_mem(16'h0123, 2);
        check("R3 mode 3 read byte0", {24'd0, rbuf[0]}, 32'h3C);
        check("R3 mode 3 read byte1", {24'd0, rbuf[1]}, 32'hC3);
        mode3 = 1'b0;
        read_mem(16'h0123, 2);
        check("R3 mode 0 read byte0", {24'd0, rbuf[0]}, 32'h3C);
        check("R3 mode 0 read byte1", {24'd0, rbuf[1]}, 32'hC3);
        check("R11 so_oe after read", {31'd0, so_oe}, 32'd0);
    endtask

    task automatic t_protect_pin();
        logic [7:0] st;
        wp_n = 1'b0;
        simple_cmd(8'h06);
        wbuf[0] = 8'hEE;
        write_mem(16'h00A0, 1);
        read_status(st);
        check("R7 no busy with wp_n low", {24'd0, st}, 32'h02);
        write_status(8'h7C);
        read_status(st);
        check("R7 status write refused", {24'd0, st}, 32'h02);
        expect_byte("R7 array unchanged", 16'h00A0, 8'h32);
        wp_n = 1'b1;
        simple_cmd(8'h04);
    endtask

    task automatic t_lock();
        logic [7:0] st;
        put_byte(16'h0005, 8'h77);
        put_byte(16'h0250, 8'h21);
        put_byte(16'h01F0, 8'h43);
        simple_cmd(8'h06);
        write_status(8'h44);
        wait_idle();
        read_status(st);
        check("R13 status fields after write", {24'd0, st}, 32'h44);
        check("R13 wd_sel port", {30'd0, wd_sel}, 32'd2);
        put_byte(16'h0005, 8'hAB);
        expect_byte("R8 first page locked", 16'h0005, 8'h77);
        put_byte(16'h0015, 8'h5E);
        expect_byte("R8 second page open", 16'h0015, 8'h5E);
        simple_cmd(8'h06);
        write_status(8'h18);
        wait_idle();
        put_byte(16'h0250, 8'hAA);
        expect_byte("R8 quarter 2 locked", 16'h0250, 8'h21);
        put_byte(16'h0005, 8'hAB);
        expect_byte("R8 first page open under quarter lock", 16'h0005, 8'hAB);
        simple_cmd(8'h06);
        write_status(8'h0C);
        wait_idle();
        put_byte(16'h01F0, 8'hBB);
        expect_byte("R8 lower half locked", 16'h01F0, 8'h43);
        simple_cmd(8'h06);
        write_status(8'h00);
        wait_idle();
    endtask

    task automatic t_read_wrap();
        simple_cmd(8'h06);
        wbuf[0] = 8'hA0;
        wbuf[1] = 8'hA1;
        write_mem(16'h03FE, 2);
        wait_idle();
        simple_cmd(8'h06);
        wbuf[0] = 8'hB0;
        wbuf[1] = 8'hB1;
        write_mem(16'h0000, 2);
        wait_idle();
        read_mem(16'hFC00 | 16'h03FE, 4);
        check("R9 read 3FE", {24'd0, rbuf[0]}, 32'hA0);
        check("R9 read 3FF", {24'd0, rbuf[1]}, 32'hA1);
        check("R9 wrap to 000", {24'd0, rbuf[2]}, 32'hB0);
        check("R9 wrap to 001", {24'd0, rbuf[3]}, 32'hB1);
    endtask

    task automatic t_trip();
        put_byte(16'h0001, 8'h5D);
        hv_flag = 1'b1;
        put_byte(16'h0001, 8'h00);
        check("R10 set pulse", set_cnt, 1);
        check("R10 no reset pulse", rst_cnt, 0);
        expect_byte("R10 zero stored", 16'h0001, 8'h00);
        put_byte(16'h0003, 8'h00);
        check("R10 reset pulse", rst_cnt, 1);
        put_byte(16'h0001, 8'h01);
        put_byte(16'h0002, 8'h00);
        check("R10 wrong data or address", set_cnt + rst_cnt, 2);
        hv_flag = 1'b0;
        put_byte(16'h0001, 8'h00);
        check("R10 flag low", set_cnt + rst_cnt, 2);
    endtask

    task automatic t_abort();
        logic [7:0] st;
        logic [7:0] dummy;
        put_byte(16'h00C0, 8'h12);
        simple_cmd(8'h06);
        cs_begin();
        send(8'h02);
        send(8'h00);
        send(8'hC0);
        send(8'h66);
        xfer_bits(8'hF0, 4, dummy);
        cs_end();
        read_status(st);
        check("R12 no busy after partial byte", {24'd0, st}, 32'h02);
        expect_byte("R12 array unchanged", 16'h00C0, 8'h12);
        simple_cmd(8'h04);
    endtask

    initial begin
        t_power_up();
        t_latch();
        t_page_and_busy();
        t_modes();
        t_protect_pin();
        t_lock();
        t_read_wrap();
        t_trip();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule